// File: doc/BRIEF.md
# Dual Parallel Port with Timer Pin Override

Two bidirectional ports of `W` pins sit behind a four-entry register interface. Each port has an output-data register and a direction register. Port A pins drive both levels. Port B pins are open-drain: they can only pull low, and a pullup provides the high level. The two top pins of port B can be taken over by two timer output signals. Each takeover is set by its own override input.

A data-register read returns the level sampled on the pins, not the stored output value. The pins pass through a two-flop synchronizer before they are read. The pins do not follow a register write directly. A second stage copies the registers on the next clock, so the pins never see a write that is only partly applied. Any read or write of the port B data register sends one active-low strobe pulse out on `hs_no`. The pulse starts two clocks after the access begins.

Top module: `pio_dual_port`

## Requirements
- R1: While `rst_ni` is low and after it is released, all direction and data registers are zero. All drive enables, `pa_do_o` and `pb_pull_o` are 0, and `hs_no` is 1.
- R2: Register select encoding is 0 = port A data, 1 = port B data, 2 = port A direction, 3 = port B direction. A write with `wr_i` high loads `wdata_i` at the clock edge. A read of select 2 or 3 returns the direction register.
- R3: `pa_oe_o` and `pa_do_o` equal the port A direction and data registers as they stood one clock earlier. A write therefore reaches the pins on the second edge after it is issued.
- R4: On port B, a pin pulls low (`pb_pull_o` bit = 1) only when its delayed direction bit is 1 and its delayed data bit is 0.
- R5: A read of select 0 or 1 returns the pin inputs delayed by two clock edges. It never returns the data register.
- R6: While `ovr_b_i` is 1, port B bit W-1 is an output whatever its direction bit says, and it pulls low exactly when `tmr_b_i` is 0.
- R7: While `ovr_a_i` is 1, port B bit W-2 is an output whatever its direction bit says, and it pulls low exactly when `tmr_a_i` is 0.
- R8: A port B data access (read or write) that starts in cycle n drives `hs_no` low for exactly one cycle, cycle n+2.
- R9: A port B data access held over several consecutive cycles gives a single pulse. Accesses to selects 0, 2 and 3 give none.
- R10: `rdata_o` is 0 whenever `rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | W | Write data |
| pa_in_i | input | W | Port A pin levels |
| pb_in_i | input | W | Port B pin levels |
| tmr_a_i | input | 1 | Timer A output signal |
| tmr_b_i | input | 1 | Timer B output signal |
| ovr_a_i | input | 1 | Hand port B bit W-2 to timer A |
| ovr_b_i | input | 1 | Hand port B bit W-1 to timer B |
| rdata_o | output | W | Read data |
| pa_oe_o | output | W | Port A drive enables |
| pa_do_o | output | W | Port A drive levels |
| pb_pull_o | output | W | Port B pull-low enables |
| hs_no | output | 1 | Handshake strobe, active low |

## Verification
The bench writes a data pattern that differs from the pins being driven, then reads it back. A design that returns the output register would fail this, and so would one that skips the synchronizer. Override bits are toggled while the direction bits are 0 and while the data bits disagree with the timers. This catches an override that is ANDed in, or one that still drives the register bit. Long port B reads and back-to-back port B accesses expose a strobe that is level-triggered, as it would give repeated or stretched pulses. Direction writes probe the one-clock pin delay: a design with no delay stage would show the new value one cycle early.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    SEL_A_DAT = 2'd0,
    SEL_B_DAT = 2'd1,
    SEL_A_DIR = 2'd2,
    SEL_B_DIR = 2'd3
  } pio_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s0_q, s1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0;
      s1_q <= '0;
    end else begin
      s0_q <= d_i;
      s1_q <= s0_q;
    end
  end
  assign q_o = s1_q;
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_dat_i,
  input  logic         we_dir_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_i,
  input  logic [1:0]   ovr_i,
  input  logic [1:0]   tmr_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] lvl_o
);
  localparam int OVR_LSB = W - 2;

  logic [W-1:0] dat_q, dir_q, dat_sh, dir_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
      dir_q <= '0;
    end else begin
      if (we_dat_i) dat_q <= wdata_i;
      if (we_dir_i) dir_q <= wdata_i;
    end
  end

  // second stage: pins see register values only after the write edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_sh <= '0;
      dir_sh <= '0;
    end else begin
      dat_sh <= dat_q;
      dir_sh <= dir_q;
    end
  end

  pio_sync #(.W(W)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_o)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b >= OVR_LSB) begin : g_ovr
      assign oe_o[b]  = dir_sh[b] | ovr_i[b-OVR_LSB];
      assign lvl_o[b] = ovr_i[b-OVR_LSB] ? tmr_i[b-OVR_LSB] : dat_sh[b];
    end else begin : g_plain
      assign oe_o[b]  = dir_sh[b];
      assign lvl_o[b] = dat_sh[b];
    end
  end

  assign dir_o = dir_q;

  a_r3_dir_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (oe_o[OVR_LSB-1:0] == $past(dir_q[OVR_LSB-1:0])));
  a_r3_dat_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lvl_o[OVR_LSB-1:0] == $past(dat_q[OVR_LSB-1:0])));
endmodule

// File: rtl/pio_strobe.sv
module pio_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  output logic hs_no
);
  logic acc_q, s1_q, low_q;
  logic start;

  assign start = acc_i & ~acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      s1_q  <= 1'b0;
      low_q <= 1'b0;
    end else begin
      acc_q <= acc_i;
      s1_q  <= start;
      low_q <= s1_q;
    end
  end

  assign hs_no = ~low_q;

  a_r8_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_no) |=> hs_no);
  a_r8_two_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_q |=> !hs_no);
  a_r9_held_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q && acc_i) |=> !s1_q);
endmodule

// File: rtl/pio_dual_port.sv
module pio_dual_port
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   sel_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pa_in_i,
  input  logic [W-1:0] pb_in_i,
  input  logic         tmr_a_i,
  input  logic         tmr_b_i,
  input  logic         ovr_a_i,
  input  logic         ovr_b_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] pa_oe_o,
  output logic [W-1:0] pa_do_o,
  output logic [W-1:0] pb_pull_o,
  output logic         hs_no
);
  pio_sel_e sel;
  logic [W-1:0] a_dir, a_pin, a_oe, a_lvl;
  logic [W-1:0] b_dir, b_pin, b_oe, b_lvl;
  logic b_acc;

  assign sel   = pio_sel_e'(sel_i);
  assign b_acc = (rd_i | wr_i) & (sel == SEL_B_DAT);

  pio_port #(.W(W)) port_a_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_dat_i(wr_i & (sel == SEL_A_DAT)),
    .we_dir_i(wr_i & (sel == SEL_A_DIR)),
    .wdata_i (wdata_i),
    .pin_i   (pa_in_i),
    .ovr_i   (2'b00),
    .tmr_i   (2'b00),
    .dir_o   (a_dir),
    .pin_o   (a_pin),
    .oe_o    (a_oe),
    .lvl_o   (a_lvl)
  );

  pio_port #(.W(W)) port_b_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_dat_i(wr_i & (sel == SEL_B_DAT)),
    .we_dir_i(wr_i & (sel == SEL_B_DIR)),
    .wdata_i (wdata_i),
    .pin_i   (pb_in_i),
    .ovr_i   ({ovr_b_i, ovr_a_i}),
    .tmr_i   ({tmr_b_i, tmr_a_i}),
    .dir_o   (b_dir),
    .pin_o   (b_pin),
    .oe_o    (b_oe),
    .lvl_o   (b_lvl)
  );

  pio_strobe strobe_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .acc_i (b_acc),
    .hs_no (hs_no)
  );

  assign pa_oe_o   = a_oe;
  assign pa_do_o   = a_lvl;
  assign pb_pull_o = b_oe & ~b_lvl;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        SEL_A_DAT: rdata_o = a_pin;
        SEL_B_DAT: rdata_o = b_pin;
        SEL_A_DIR: rdata_o = a_dir;
        SEL_B_DIR: rdata_o = b_dir;
      endcase
    end
  end

  a_r6_tmr_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_b_i |-> (pb_pull_o[W-1] == !tmr_b_i));
  a_r7_tmr_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_a_i |-> (pb_pull_o[W-2] == !tmr_a_i));
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
endmodule

// File: tb/pio_dual_port_tb_top.sv
`timescale 1ns/1ps
module pio_dual_port_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [W-1:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic tmr_a = 1'b0, tmr_b = 1'b0, ovr_a = 1'b0, ovr_b = 1'b0;
  logic [W-1:0] rdata, pa_oe, pa_do, pb_pull;
  logic hs_n;

  always #10 clk = ~clk;

  pio_dual_port #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .pa_in_i(pa_in), .pb_in_i(pb_in),
    .tmr_a_i(tmr_a), .tmr_b_i(tmr_b), .ovr_a_i(ovr_a), .ovr_b_i(ovr_b),
    .rdata_o(rdata), .pa_oe_o(pa_oe), .pa_do_o(pa_do), .pb_pull_o(pb_pull),
    .hs_no(hs_n)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [W-1:0] m_adat, m_adir, m_bdat, m_bdir;
  logic [W-1:0] m_adat_p, m_adir_p, m_bdat_p, m_bdir_p;
  logic [W-1:0] qa[$], qb[$];
  bit qh[$];
  bit m_acc;

  task automatic m_reset();
    m_adat = '0; m_adir = '0; m_bdat = '0; m_bdir = '0;
    m_adat_p = '0; m_adir_p = '0; m_bdat_p = '0; m_bdir_p = '0;
    qa = '{'0, '0}; qb = '{'0, '0}; qh = '{0, 0}; m_acc = 0;
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      bit acc;
      acc = (rd || wr) && (sel == 2'd1);
      m_adat_p = m_adat; m_adir_p = m_adir; m_bdat_p = m_bdat; m_bdir_p = m_bdir;
      if (wr) case (sel)
        2'd0: m_adat = wdata;
        2'd1: m_bdat = wdata;
        2'd2: m_adir = wdata;
        default: m_bdir = wdata;
      endcase
      qa.push_back(pa_in); void'(qa.pop_front());
      qb.push_back(pb_in); void'(qb.pop_front());
      qh.push_back(acc && !m_acc); void'(qh.pop_front());
      m_acc = acc;
    end
  end

  function automatic logic [W-1:0] exp_pull();
    logic [W-1:0] oe, lv;
    oe = m_bdir_p; lv = m_bdat_p;
    if (ovr_a) begin oe[W-2] = 1'b1; lv[W-2] = tmr_a; end
    if (ovr_b) begin oe[W-1] = 1'b1; lv[W-1] = tmr_b; end
    return oe & ~lv;
  endfunction

  // compare every cycle, midway between drive (negedge) and next posedge
  always @(negedge clk) begin
    #5;
    if (cmp_on) begin
      logic [W-1:0] er;
      chk("R3 pa_oe", pa_oe, m_adir_p);
      chk("R3 pa_do", pa_do, m_adat_p);
      chk("R4 pb_pull", {2'b00, pb_pull[W-3:0]}, {2'b00, exp_pull() & {2'b00, {(W-2){1'b1}}}});
      chk("R6 pb_pull msb", W'(pb_pull[W-1]), W'(exp_pull() >> (W-1)));
      chk("R7 pb_pull bit", W'(pb_pull[W-2]), W'((exp_pull() >> (W-2)) & 1));
      chk("R8 hs_no", W'(hs_n), W'(!qh[0]));
      if (!rd) er = '0;
      else case (sel)
        2'd0: er = qa[0];
        2'd1: er = qb[0];
        2'd2: er = m_adir;
        default: er = m_bdir;
      endcase
      if (!rd) chk("R10 rdata idle", rdata, er);
      else if (sel < 2) chk("R5 pin read", rdata, er);
      else chk("R2 dir read", rdata, er);
    end
  end

  task automatic cyc(input logic [1:0] s, input logic r, input logic w, input logic [W-1:0] d);
    @(negedge clk);
    sel = s; rd = r; wr = w; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(2'd0, 1'b0, 1'b0, '0);
  endtask

  bit done = 0;

  initial begin
    #5_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pa_oe", pa_oe, '0);
    chk("R1 pa_do", pa_do, '0);
    chk("R1 pb_pull", pb_pull, '0);
    chk("R1 hs_no", W'(hs_n), W'(1));
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cyc(2'd2, 1'b1, 1'b0, '0);
    chk("R1 dir read", rdata, '0);
    cyc(2'd3, 1'b1, 1'b0, '0);
    chk("R1 dir read b", rdata, '0);

    // R2/R3: direction and data writes, port A
    cyc(2'd2, 1'b0, 1'b1, 8'hF0);
    cyc(2'd0, 1'b0, 1'b1, 8'hA5);
    cyc(2'd2, 1'b1, 1'b0, '0);
    idle(3);
    // R5: read data returns pins, not register
    pa_in = 8'h3C;
    idle(3);
    cyc(2'd0, 1'b1, 1'b0, '0);
    idle(1);
    // R4: port B open drain
    cyc(2'd3, 1'b0, 1'b1, 8'h0F);
    cyc(2'd1, 1'b0, 1'b1, 8'h05);
    idle(4);
    pb_in = 8'h5A;
    // R9: held read of port B data -> single pulse
    for (int i = 0; i < 5; i++) cyc(2'd1, 1'b1, 1'b0, '0);
    idle(4);
    begin
      int lows = 0;
      for (int i = 0; i < 5; i++) cyc(2'd1, 1'b1, 1'b0, '0);
      for (int i = 0; i < 6; i++) begin
        @(posedge clk); #3;
        if (!hs_n) lows++;
        if (i == 0) begin @(negedge clk); sel = 2'd0; rd = 0; end
      end
      chk("R9 held access pulses", W'(lows), W'(0));
    end
    // R9: other registers give no pulse
    cyc(2'd0, 1'b0, 1'b1, 8'h11);
    cyc(2'd2, 1'b1, 1'b0, '0);
    cyc(2'd3, 1'b0, 1'b1, 8'h0F);
    idle(4);
    // R8: back-to-back separate accesses
    cyc(2'd1, 1'b0, 1'b1, 8'h00);
    idle(1);
    cyc(2'd1, 1'b1, 1'b0, '0);
    idle(4);
    // R6/R7: overrides with direction bits 0 and data disagreeing
    cyc(2'd1, 1'b0, 1'b1, 8'hC0);
    idle(2);
    ovr_b = 1; tmr_b = 0;
    idle(2);
    tmr_b = 1;
    idle(1);
    ovr_a = 1; tmr_a = 0;
    idle(2);
    tmr_a = 1; tmr_b = 0;
    idle(2);
    ovr_a = 0; ovr_b = 0;
    cyc(2'd3, 1'b0, 1'b1, 8'hC0);
    cyc(2'd1, 1'b0, 1'b1, 8'h40);
    idle(3);
    ovr_a = 1; tmr_a = 0;
    idle(2);
    // mixed traffic
    for (int i = 0; i < 200; i++) begin
      pa_in = W'($urandom); pb_in = W'($urandom);
      tmr_a = 1'($urandom); tmr_b = 1'($urandom);
      ovr_a = 1'($urandom); ovr_b = 1'($urandom);
      cyc(2'($urandom), 1'($urandom), 1'($urandom), W'($urandom));
    end
    idle(4);
    cmp_on = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule